// File: doc/BRIEF.md
# Programmable Event-to-Task Interconnect

This block lets peripherals trigger one another without the processor. Single-cycle event pulses enter on a generic event vector and single-cycle strobes leave on a generic task vector. In between sit 32 channels. Each channel picks one event and drives up to two tasks: a primary task and a second "fork" task.

Software programs the channels through a word-addressed register port. A channel is switched on and off through write-1-to-set and write-1-to-clear aliases of a shared enable word. Six channel groups each hold a membership mask. A group's enable task switches all of its member channels on at once, and its disable task switches them all off.

The group tasks also sit in the task index space, after the peripheral tasks. This lets one channel switch whole groups of other channels when an event arrives. A strobe aimed at a group task stays inside the block and never appears on the task vector.

Top module: `evt_xbar`

## Requirements
- R1: After reset:
  - every channel enable reads 0;
  - every group mask reads 0;
  - every endpoint field reads 31, the reserved "unconnected" index.
- R2: A write to address 0x01 sets each channel-enable bit whose `reg_wdata` bit is 1 and leaves every other enable bit unchanged.
- R3: A write to address 0x02 clears each channel-enable bit whose `reg_wdata` bit is 1. Writing all ones disables every channel.
- R4: Address 0x00 reads the enable word, with bit n = 1 when channel n is enabled. A set or clear write shows in the read from the following cycle.
- R5: Address 0x40+n holds channel n's event index (0–15) and address 0x80+n its primary task index, both readable. When channel n is enabled and its event pulses in cycle k, its task strobes in cycle k+1 for one cycle. A disabled channel never strobes.
- R6: Address 0xC0+n holds channel n's fork task index. The fork task strobes in the same cycle as the primary task.
- R7: When several channels, or a channel's primary and fork endpoints, select the same task, their strobes are ORed into a single strobe.
- R8: The index 31 (and any other index with no matching event or task) is "unconnected". An unconnected event endpoint never fires its channel, and an unconnected task endpoint never strobes.
- R9: Address 0x10+g holds group g's membership mask, with bit n meaning channel n belongs to group g. The mask can be read back, written whole, or cleared by writing 0.
- R10: Group task registers:
  - A write to 0x20+g with bit 0 = 1 ORs group g's mask into the enable word.
  - A write to 0x30+g with bit 0 = 1 clears the enable bits in that mask.
  - A write with bit 0 = 0 to either address has no effect.
- R11: If group g's enable task and disable task fire in the same cycle, the disable task wins, and the member channels end up disabled.
- R12: Task index 16+2g is group g's enable task and 17+2g its disable task. When a channel strobes one of these in cycle k+1, the enable word changes in cycle k+2. The strobe does not appear on `task_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Word address for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_i | input | 16 | Event pulses from peripherals |
| task_o | output | 16 | Task strobes to peripherals, registered |

## Verification
The assertions assume at most one register write per cycle, and that a pulse on `evt_i` belongs to the cycle in which it is sampled. The set-alias checks also assume that no group disable task lands in the same cycle, because a clear always beats a set. The bench keeps within these assumptions: it drives one write at a time, with idle cycles between writes, and it only fires group tasks from channel strobes in cycles with no software write. Its scoreboard expects `task_o` to be zero in every cycle that has no queued pulse. Any stray or late strobe is therefore caught.

// File: rtl/evt_xbar_pkg.sv
package evt_xbar_pkg;

    localparam int ADDR_W = 8;

    // upper two address bits pick the register region
    typedef enum logic [1:0] {
        RGN_CTRL = 2'd0,
        RGN_EVT  = 2'd1,
        RGN_TSK  = 2'd2,
        RGN_FORK = 2'd3
    } region_e;

    // inside the control region, address bits 5:4 pick the sub-block
    typedef enum logic [1:0] {
        SUB_EN   = 2'd0,
        SUB_MASK = 2'd1,
        SUB_GON  = 2'd2,
        SUB_GOFF = 2'd3
    } ctrl_sub_e;

    localparam logic [3:0] EN_STATE = 4'd0;
    localparam logic [3:0] EN_SET   = 4'd1;
    localparam logic [3:0] EN_CLR   = 4'd2;

    // width that holds every index plus one reserved all-ones value
    function automatic int ep_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/evt_xbar_regs.sv
module evt_xbar_regs
    import evt_xbar_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6,
    parameter int EVT_W   = 5,
    parameter int TSK_W   = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_CH-1:0]               wdata,
    input  logic [NUM_GRP-1:0]              grp_on_hw,
    input  logic [NUM_GRP-1:0]              grp_off_hw,
    output logic [NUM_CH-1:0]               rdata,
    output logic [NUM_CH-1:0]               chan_en,
    output logic [NUM_GRP-1:0][NUM_CH-1:0]  grp_mask,
    output logic [NUM_GRP-1:0]              grp_on_req,
    output logic [NUM_GRP-1:0]              grp_off_req,
    output logic [EVT_W-1:0]                evt_sel  [NUM_CH],
    output logic [TSK_W-1:0]                tsk_sel  [NUM_CH],
    output logic [TSK_W-1:0]                fork_sel [NUM_CH]
);

    region_e     rgn;
    ctrl_sub_e   sub;
    logic [3:0]  lo;
    logic [5:0]  ch_idx;
    logic        wr_ctrl;
    logic [NUM_CH-1:0] set_sw, clr_sw, grp_set, grp_clr;

    assign rgn     = region_e'(addr[7:6]);
    assign sub     = ctrl_sub_e'(addr[5:4]);
    assign lo      = addr[3:0];
    assign ch_idx  = addr[5:0];
    assign wr_ctrl = we && (rgn == RGN_CTRL);

    assign set_sw = (wr_ctrl && sub == SUB_EN && lo == EN_SET) ? wdata : '0;
    assign clr_sw = (wr_ctrl && sub == SUB_EN && lo == EN_CLR) ? wdata : '0;

    // software and channel-driven group tasks merge into one request each
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_req
        localparam logic [3:0] GI = 4'(g);
        assign grp_on_req[g]  = grp_on_hw[g] |
                                (wr_ctrl && sub == SUB_GON && lo == GI && wdata[0]);
        assign grp_off_req[g] = grp_off_hw[g] |
                                (wr_ctrl && sub == SUB_GOFF && lo == GI && wdata[0]);
    end

    // disable beats enable within a group; any clear beats any set
    always_comb begin
        grp_set = '0;
        grp_clr = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp_on_req[g] && !grp_off_req[g]) grp_set |= grp_mask[g];
            if (grp_off_req[g])                   grp_clr |= grp_mask[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_en <= '0;
        else        chan_en <= (chan_en | set_sw | grp_set) & ~(clr_sw | grp_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_mask <= '0;
        end else begin
            for (int g = 0; g < NUM_GRP; g++)
                if (wr_ctrl && sub == SUB_MASK && lo == 4'(g)) grp_mask[g] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                evt_sel[c]  <= '1;
                tsk_sel[c]  <= '1;
                fork_sel[c] <= '1;
            end
        end else if (we && ch_idx < 6'(NUM_CH)) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_idx == 6'(c)) begin
                    if (rgn == RGN_EVT)  evt_sel[c]  <= wdata[EVT_W-1:0];
                    if (rgn == RGN_TSK)  tsk_sel[c]  <= wdata[TSK_W-1:0];
                    if (rgn == RGN_FORK) fork_sel[c] <= wdata[TSK_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rgn)
            RGN_CTRL: begin
                if (sub == SUB_EN && lo == EN_STATE) rdata = chan_en;
                if (sub == SUB_MASK)
                    for (int g = 0; g < NUM_GRP; g++)
                        if (lo == 4'(g)) rdata = grp_mask[g];
            end
            RGN_EVT:
                for (int c = 0; c < NUM_CH; c++)
                    if (ch_idx == 6'(c)) rdata = NUM_CH'(evt_sel[c]);
            RGN_TSK:
                for (int c = 0; c < NUM_CH; c++)
                    if (ch_idx == 6'(c)) rdata = NUM_CH'(tsk_sel[c]);
            RGN_FORK:
                for (int c = 0; c < NUM_CH; c++)
                    if (ch_idx == 6'(c)) rdata = NUM_CH'(fork_sel[c]);
        endcase
    end

endmodule

// File: rtl/evt_xbar_route.sv
module evt_xbar_route #(
    parameter int NUM_CH  = 32,
    parameter int NUM_EVT = 16,
    parameter int TSK_TOT = 28,
    parameter int EVT_W   = 5,
    parameter int TSK_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   chan_en,
    input  logic [NUM_EVT-1:0]  evt_i,
    input  logic [EVT_W-1:0]    evt_sel  [NUM_CH],
    input  logic [TSK_W-1:0]    tsk_sel  [NUM_CH],
    input  logic [TSK_W-1:0]    fork_sel [NUM_CH],
    output logic [TSK_TOT-1:0]  strobe_q
);

    logic [NUM_CH-1:0]  fire;
    logic [TSK_TOT-1:0] hit;

    // an index outside 0..NUM_EVT-1 matches no event
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            fire[c] = 1'b0;
            for (int e = 0; e < NUM_EVT; e++)
                if (evt_sel[c] == EVT_W'(e)) fire[c] = evt_i[e];
            fire[c] = fire[c] & chan_en[c];
        end
    end

    // OR-merge of every primary and fork endpoint onto the task space
    always_comb begin
        hit = '0;
        for (int t = 0; t < TSK_TOT; t++)
            for (int c = 0; c < NUM_CH; c++)
                if (fire[c] && (tsk_sel[c] == TSK_W'(t) || fork_sel[c] == TSK_W'(t)))
                    hit[t] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= '0;
        else        strobe_q <= hit;
    end

endmodule

// File: rtl/evt_xbar.sv
module evt_xbar
    import evt_xbar_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6,
    parameter int NUM_EVT = 16,
    parameter int NUM_TSK = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [NUM_CH-1:0]   reg_wdata,
    output logic [NUM_CH-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0]  evt_i,
    output logic [NUM_TSK-1:0]  task_o
);

    localparam int TSK_TOT = NUM_TSK + 2 * NUM_GRP;
    localparam int EVT_W   = ep_width(NUM_EVT);
    localparam int TSK_W   = ep_width(TSK_TOT);

    logic [NUM_CH-1:0]              chan_en;
    logic [NUM_GRP-1:0][NUM_CH-1:0] grp_mask;
    logic [NUM_GRP-1:0]             grp_on_req, grp_off_req;
    logic [NUM_GRP-1:0]             grp_on_hw, grp_off_hw;
    logic [EVT_W-1:0]               evt_sel  [NUM_CH];
    logic [TSK_W-1:0]               tsk_sel  [NUM_CH];
    logic [TSK_W-1:0]               fork_sel [NUM_CH];
    logic [TSK_TOT-1:0]             strobe_q;

    evt_xbar_regs #(
        .NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP), .EVT_W(EVT_W), .TSK_W(TSK_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .grp_on_hw(grp_on_hw), .grp_off_hw(grp_off_hw),
        .rdata(reg_rdata), .chan_en(chan_en), .grp_mask(grp_mask),
        .grp_on_req(grp_on_req), .grp_off_req(grp_off_req),
        .evt_sel(evt_sel), .tsk_sel(tsk_sel), .fork_sel(fork_sel)
    );

    evt_xbar_route #(
        .NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .TSK_TOT(TSK_TOT),
        .EVT_W(EVT_W), .TSK_W(TSK_W)
    ) u_route (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .evt_i(evt_i),
        .evt_sel(evt_sel), .tsk_sel(tsk_sel), .fork_sel(fork_sel),
        .strobe_q(strobe_q)
    );

    // task index NUM_TSK+2g enables group g, NUM_TSK+2g+1 disables it
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_hw
        assign grp_on_hw[g]  = strobe_q[NUM_TSK + 2*g];
        assign grp_off_hw[g] = strobe_q[NUM_TSK + 2*g + 1];
    end

    assign task_o = strobe_q[NUM_TSK-1:0];

endmodule

// File: rtl/evt_xbar_chk.sv
module evt_xbar_chk #(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6,
    parameter int NUM_EVT = 16,
    parameter int NUM_TSK = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            reg_we,
    input logic [7:0]                      reg_addr,
    input logic [NUM_CH-1:0]               reg_wdata,
    input logic [NUM_EVT-1:0]              evt_i,
    input logic [NUM_TSK-1:0]              task_o,
    input logic [NUM_CH-1:0]               chan_en,
    input logic [NUM_GRP-1:0][NUM_CH-1:0]  grp_mask,
    input logic [NUM_GRP-1:0]              grp_on_req,
    input logic [NUM_GRP-1:0]              grp_off_req
);

    // R2
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h01 && grp_off_req == '0)
        |=> ((chan_en & $past(reg_wdata)) == $past(reg_wdata)));

    // R2
    set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h01 && grp_on_req == '0 && grp_off_req == '0)
        |=> ((chan_en & ~$past(reg_wdata)) == ($past(chan_en) & ~$past(reg_wdata))));

    // R3
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h02) |=> ((chan_en & $past(reg_wdata)) == '0));

    // R5
    task_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (task_o != '0) |-> ($past(chan_en) != '0 && $past(evt_i) != '0));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        // R11
        grp_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_off_req[g] |=> ((chan_en & $past(grp_mask[g])) == '0));

        // R10
        grp_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_on_req[g] && grp_off_req == '0 && !(reg_we && reg_addr == 8'h02))
            |=> ((chan_en & $past(grp_mask[g])) == $past(grp_mask[g])));
    end

endmodule

bind evt_xbar evt_xbar_chk #(
    .NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP), .NUM_EVT(NUM_EVT), .NUM_TSK(NUM_TSK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_i(evt_i), .task_o(task_o), .chan_en(chan_en),
    .grp_mask(grp_mask), .grp_on_req(grp_on_req), .grp_off_req(grp_off_req)
);

// File: tb/sim_evt_xbar.sv
`timescale 1ns/1ps
module sim_evt_xbar;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] evt_i = '0;
    logic [15:0] task_o;

    always #5 clk = ~clk;

    evt_xbar u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .task_o(task_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [15:0] val;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every cycle task_o must match a queued item or be idle
    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                exp_t it;
                it = exp_q.pop_front();
                chk(task_o == it.val, it.req, 32'(task_o), 32'(it.val));
            end else if (task_o != '0) begin
                chk(1'b0, "R5 unexpected strobe", 32'(task_o), 32'h0);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // driver: one-cycle event pulse, strobe expected one cycle later
    task automatic pulse(input logic [15:0] ev, input logic [15:0] exp, input string req);
        @(negedge clk);
        evt_i = ev;
        exp_q.push_back('{cyc + 1, exp, req});
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(8'h00, 32'h0, "R1 enable");
        rd_chk(8'h10, 32'h0, "R1 mask");
        rd_chk(8'h40, 32'd31, "R1 event ep");
        rd_chk(8'hDF, 32'd31, "R1 fork ep");

        // R5 routing, only once enabled
        wr(8'h40, 32'd3);
        wr(8'h80, 32'd5);
        rd_chk(8'h40, 32'd3, "R5 event ep readback");
        rd_chk(8'h80, 32'd5, "R5 task ep readback");
        pulse(16'h0008, 16'h0000, "R5 disabled channel");
        wr(8'h01, 32'h1);
        rd_chk(8'h00, 32'h1, "R4 enable read");
        pulse(16'h0008, 16'h0020, "R5 route");
        pulse(16'h0010, 16'h0000, "R5 other event");

        // R6 fork
        wr(8'hC0, 32'd9);
        pulse(16'h0008, 16'h0220, "R6 fork");

        // R7 OR merge, R2 set alias keeps other bits
        wr(8'h41, 32'd4);
        wr(8'h81, 32'd5);
        wr(8'h01, 32'h2);
        rd_chk(8'h00, 32'h3, "R2 set keeps");
        pulse(16'h0018, 16'h0220, "R7 merge");
        pulse(16'h0010, 16'h0020, "R7 second channel");

        // R8 unconnected endpoints
        wr(8'h42, 32'd7);
        wr(8'h82, 32'd31);
        wr(8'h01, 32'h4);
        pulse(16'h0080, 16'h0000, "R8 task unconnected");
        wr(8'h83, 32'd6);
        wr(8'h01, 32'h8);
        pulse(16'hFFFF, 16'h0220, "R8 event unconnected");

        // R3 clear alias
        wr(8'h02, 32'h1);
        rd_chk(8'h00, 32'hE, "R3 clear one");
        pulse(16'h0008, 16'h0000, "R3 cleared channel");
        wr(8'h02, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0, "R3 clear all");

        // R9 masks, R10 group tasks
        wr(8'h11, 32'h3);
        rd_chk(8'h11, 32'h3, "R9 mask readback");
        rd_chk(8'h10, 32'h0, "R9 other mask");
        wr(8'h21, 32'h1);
        rd_chk(8'h00, 32'h3, "R10 group enable");
        wr(8'h31, 32'h0);
        rd_chk(8'h00, 32'h3, "R10 zero write ignored");
        wr(8'h31, 32'h1);
        rd_chk(8'h00, 32'h0, "R10 group disable");
        wr(8'h21, 32'h0);
        rd_chk(8'h00, 32'h0, "R10 zero enable ignored");

        // R12 channel drives group 1 enable (index 18)
        wr(8'h44, 32'd8);
        wr(8'h84, 32'd18);
        wr(8'h01, 32'h10);
        pulse(16'h0100, 16'h0000, "R12 internal strobe hidden");
        rd_chk(8'h00, 32'h10, "R12 not yet applied");
        @(negedge clk);
        rd_chk(8'h00, 32'h13, "R12 applied next cycle");

        // R11 enable (18) and disable (19) together
        wr(8'h45, 32'd9);
        wr(8'h85, 32'd18);
        wr(8'hC5, 32'd19);
        wr(8'h01, 32'h20);
        rd_chk(8'h00, 32'h33, "R11 before");
        pulse(16'h0200, 16'h0000, "R11 hidden");
        @(negedge clk);
        rd_chk(8'h00, 32'h30, "R11 disable wins");

        // R9 cleared mask makes group enable a no-op
        wr(8'h11, 32'h0);
        rd_chk(8'h11, 32'h0, "R9 mask cleared");
        pulse(16'h0100, 16'h0000, "R9 hidden");
        @(negedge clk);
        rd_chk(8'h00, 32'h30, "R9 empty group");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 queue drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        report();
    end

endmodule